// File: doc/BRIEF.md
# Four-Line Cascadable Interrupt Controller

This block takes four asynchronous interrupt request lines and brings each one into the clock domain through its own synchronizer chain. Each line can be set to level or edge triggering and can be masked on its own. The block presents one request at a time to the CPU side as a valid flag and an 8-bit vector. A presented vector is held until the CPU acknowledges it. When several requests are active, a fixed priority picks the winner.

Lines 0 and 1 can each be cascaded behind an external device. In cascade mode, the pin of line 2 (for line 0) or of line 3 (for line 1) stops acting as a request input. It becomes an output that pulses to ask the external device for an interrupt type byte. The block takes that byte from an 8-bit data bus and presents it as the vector.

In slave mode the block sits behind an external controller. The line-1 pin becomes a select input, the line-3 pin becomes a request output, and the type byte is taken from the bus when select rises while line 0 is pending.

Top module: `intc4_cascade`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `irq_valid_o`, `irq_vector_o`, `pin_out_o` and `pin_oe_o` are all zero.
- R2: A level-mode line asserted at its pin is presented 3 clock edges after the pin changes, with vector 12 plus the line number. Lines are numbered 0 to 3 by their bit position in `req_pin_i`.
- R3: A level-mode line counts only while its synchronized level is high. A pulse that ends while the line is masked leaves nothing pending.
- R4: A line whose `mask_i` bit is 1 is never presented. An edge-mode line records a rising edge while masked and is presented one edge after its mask bit clears.
- R5: Among unmasked active lines, line 0 wins over 1, 1 over 2, and 2 over 3.
- R6: While `irq_valid_o` is high, the vector holds steady until `cpu_ack_i` is sampled high. At that edge `irq_valid_o` drops for at least one cycle, and the next winner is presented on the following edge.
- R7: With `casc_en_i[0]`=1 (and `slave_en_i`=0), the line-2 pin is driven (`pin_oe_o[2]`=1) and no longer counts as a request. A line-0 win drives `pin_out_o[2]` high for exactly one cycle. The byte on `ext_type_i` during the following cycle becomes the vector.
- R8: With `casc_en_i[1]`=1, line 1 follows the same handshake, using `pin_out_o[3]` (with `pin_oe_o[3]`=1) as the acknowledge.
- R9: With `slave_en_i`=1, a rising synchronized level on the line-1 pin while unmasked line 0 is active presents `ext_type_i` as the vector, 3 edges after the select pin rises. A select rise without line 0 presents nothing.
- R10: With `slave_en_i`=1, `pin_oe_o` is 4'b1000. `pin_out_o[3]` follows the synchronized, unmasked level of line 2 one edge later, and line 2 is never presented to the CPU.
- R11: An edge-mode request that has been acknowledged is not presented again without a new rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pin_i | input | 4 | Asynchronous request / select pins, bit = line |
| edge_mode_i | input | 4 | 1 = edge triggered, 0 = level triggered, per line |
| mask_i | input | 4 | 1 = line masked |
| casc_en_i | input | 2 | Cascade enable for line 0 (bit 0) and line 1 (bit 1) |
| slave_en_i | input | 1 | Slave mode enable |
| cpu_ack_i | input | 1 | CPU acknowledge of the presented vector |
| ext_type_i | input | 8 | External interrupt type bus |
| irq_valid_o | output | 1 | A vector is presented |
| irq_vector_o | output | 8 | Presented vector |
| pin_out_o | output | 4 | Value driven on pins that act as outputs |
| pin_oe_o | output | 4 | Output enable per pin |

## Verification
A level request is due 3 edges after its pin changes: two synchronizer stages and the output register. An edge request is due 4 edges after its pin changes, because the pending bit adds one register. In a cascade, the acknowledge pin is high after the third edge and low after the fourth, and the captured vector appears after the fifth. The bench drives inputs on falling edges, waits exactly that many rising edges, and samples on the following falling edge. It also changes the bus byte between the acknowledge cycle and the capture cycle, so a capture in the wrong cycle is caught.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned LINES  = 4;
  localparam int unsigned IDX_W  = $clog2(LINES);
  localparam int unsigned TYPE_W = 8;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_PULSE = 2'd1,
    S_GRAB  = 2'd2,
    S_SHOW  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/intc_trigger.sv
module intc_trigger #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] edge_mode_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] active_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] pend_q;

  assign rise_o = sync_i & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= sync_i;
      pend_q <= (pend_q & ~clr_i) | (rise_o & edge_mode_i);
    end
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_sel
    assign active_o[g] = edge_mode_i[g] ? pend_q[g] : sync_i[g];
  end
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int unsigned WIDTH = 4,
  localparam int unsigned IW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] req_i,
  output logic             any_o,
  output logic [IW-1:0]    idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/intc_seq.sv
module intc_seq
  import intc_pkg::*;
#(
  parameter int unsigned VEC_BASE = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slave_en_i,
  input  logic              slave_go_i,
  input  logic              cand_any_i,
  input  logic [IDX_W-1:0]  cand_idx_i,
  input  logic              cand_casc_i,
  input  logic              cpu_ack_i,
  input  logic [TYPE_W-1:0] ext_type_i,
  output logic              irq_valid_o,
  output logic [TYPE_W-1:0] irq_vector_o,
  output logic              casc_ack0_o,
  output logic              casc_ack1_o,
  output logic [LINES-1:0]  clr_o
);
  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  sel_q, sel_d;
  logic [TYPE_W-1:0] vec_q, vec_d;
  logic              valid_q, ack0_q, ack1_q;

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    vec_d   = vec_q;
    clr_o   = '0;
    unique case (state_q)
      S_IDLE: begin
        if (slave_en_i) begin
          if (slave_go_i) begin
            state_d = S_SHOW;
            sel_d   = '0;
            vec_d   = ext_type_i;
          end
        end else if (cand_any_i) begin
          sel_d = cand_idx_i;
          if (cand_casc_i) begin
            state_d = S_PULSE;
          end else begin
            state_d = S_SHOW;
            vec_d   = TYPE_W'(VEC_BASE) + TYPE_W'(cand_idx_i);
          end
        end
      end
      S_PULSE: state_d = S_GRAB;
      S_GRAB: begin
        state_d = S_SHOW;
        vec_d   = ext_type_i;
      end
      S_SHOW: begin
        if (cpu_ack_i) begin
          state_d      = S_IDLE;
          clr_o[sel_q] = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      sel_q   <= '0;
      vec_q   <= '0;
      valid_q <= 1'b0;
      ack0_q  <= 1'b0;
      ack1_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      vec_q   <= vec_d;
      valid_q <= (state_d == S_SHOW);
      ack0_q  <= (state_d == S_PULSE) && (sel_d == IDX_W'(0));
      ack1_q  <= (state_d == S_PULSE) && (sel_d == IDX_W'(1));
    end
  end

  assign irq_valid_o  = valid_q;
  assign irq_vector_o = vec_q;
  assign casc_ack0_o  = ack0_q;
  assign casc_ack1_o  = ack1_q;
endmodule

// File: rtl/intc4_cascade.sv
module intc4_cascade
  import intc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned VEC_BASE    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  req_pin_i,
  input  logic [LINES-1:0]  edge_mode_i,
  input  logic [LINES-1:0]  mask_i,
  input  logic [1:0]        casc_en_i,
  input  logic              slave_en_i,
  input  logic              cpu_ack_i,
  input  logic [TYPE_W-1:0] ext_type_i,
  output logic              irq_valid_o,
  output logic [TYPE_W-1:0] irq_vector_o,
  output logic [LINES-1:0]  pin_out_o,
  output logic [LINES-1:0]  pin_oe_o
);
  localparam logic [LINES-1:0] SEL_LINE = LINES'(2);

  logic [LINES-1:0] sync_w, active_w, rise_w, clr_w, role_cpu, cand_w;
  logic             cand_any, cand_casc, slave_go;
  logic [IDX_W-1:0] cand_idx;
  logic             ack0_w, ack1_w;
  logic             slave_req_q;
  logic [LINES-1:0] oe_q;

  intc_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(req_pin_i), .sync_o(sync_w)
  );

  intc_trigger #(.WIDTH(LINES)) u_trig (
    .clk(clk), .rst(rst), .sync_i(sync_w), .edge_mode_i(edge_mode_i),
    .clr_i(clr_w), .active_o(active_w), .rise_o(rise_w)
  );

  always_comb begin
    role_cpu[0] = 1'b1;
    role_cpu[1] = ~slave_en_i;
    role_cpu[2] = ~slave_en_i & ~casc_en_i[0];
    role_cpu[3] = ~slave_en_i & ~casc_en_i[1];
  end

  assign cand_w = active_w & ~mask_i & role_cpu;

  intc_prio #(.WIDTH(LINES)) u_prio (
    .req_i(cand_w), .any_o(cand_any), .idx_o(cand_idx)
  );

  assign cand_casc = ((cand_idx == IDX_W'(0)) & casc_en_i[0]) |
                     ((cand_idx == IDX_W'(1)) & casc_en_i[1]);
  assign slave_go  = active_w[0] & ~mask_i[0] & (|(rise_w & SEL_LINE));

  intc_seq #(.VEC_BASE(VEC_BASE)) u_seq (
    .clk(clk), .rst(rst), .slave_en_i(slave_en_i), .slave_go_i(slave_go),
    .cand_any_i(cand_any), .cand_idx_i(cand_idx), .cand_casc_i(cand_casc),
    .cpu_ack_i(cpu_ack_i), .ext_type_i(ext_type_i),
    .irq_valid_o(irq_valid_o), .irq_vector_o(irq_vector_o),
    .casc_ack0_o(ack0_w), .casc_ack1_o(ack1_w), .clr_o(clr_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      slave_req_q <= 1'b0;
      oe_q        <= '0;
    end else begin
      slave_req_q <= slave_en_i & sync_w[2] & ~mask_i[2];
      oe_q        <= {slave_en_i | casc_en_i[1], ~slave_en_i & casc_en_i[0], 2'b00};
    end
  end

  assign pin_out_o = {ack1_w | slave_req_q, ack0_w, 2'b00};
  assign pin_oe_o  = oe_q;
endmodule

// File: rtl/intc4_cascade_chk.sv
module intc4_cascade_chk (
  input logic       clk,
  input logic       rst,
  input logic       cpu_ack_i,
  input logic [7:0] ext_type_i,
  input logic       irq_valid_o,
  input logic [7:0] irq_vector_o,
  input logic [3:0] pin_out_o
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq_valid_o && pin_out_o == 4'b0000));

  a_r6_vec_hold: assert property (@(posedge clk) disable iff (rst)
    (irq_valid_o && !cpu_ack_i) |=> (irq_valid_o && $stable(irq_vector_o)));

  a_r6_ack_drops: assert property (@(posedge clk) disable iff (rst)
    (irq_valid_o && cpu_ack_i) |=> !irq_valid_o);

  a_r7_ack_single: assert property (@(posedge clk) disable iff (rst)
    pin_out_o[2] |=> !pin_out_o[2]);

  a_r7_type_capture: assert property (@(posedge clk) disable iff (rst)
    $fell(pin_out_o[2]) |=> (irq_valid_o && irq_vector_o == $past(ext_type_i)));
endmodule

bind intc4_cascade intc4_cascade_chk u_chk (
  .clk(clk), .rst(rst), .cpu_ack_i(cpu_ack_i), .ext_type_i(ext_type_i),
  .irq_valid_o(irq_valid_o), .irq_vector_o(irq_vector_o), .pin_out_o(pin_out_o)
);

// File: tb/intc4_cascade_bench.sv
module intc4_cascade_bench;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] req_pin_i, edge_mode_i, mask_i;
  logic [1:0] casc_en_i;
  logic       slave_en_i, cpu_ack_i;
  logic [7:0] ext_type_i;
  logic       irq_valid_o;
  logic [7:0] irq_vector_o;
  logic [3:0] pin_out_o, pin_oe_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  intc4_cascade u_intc4_cascade (
    .clk(clk), .rst(rst), .req_pin_i(req_pin_i), .edge_mode_i(edge_mode_i),
    .mask_i(mask_i), .casc_en_i(casc_en_i), .slave_en_i(slave_en_i),
    .cpu_ack_i(cpu_ack_i), .ext_type_i(ext_type_i),
    .irq_valid_o(irq_valid_o), .irq_vector_o(irq_vector_o),
    .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string rq, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic ack();
    cpu_ack_i = 1'b1;
    tick(1);
    cpu_ack_i = 1'b0;
  endtask

  function automatic int lowest(input int v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return -1;
  endfunction

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_pin_i = '0; edge_mode_i = '0; mask_i = '0;
    casc_en_i = '0; slave_en_i = 1'b0; cpu_ack_i = 1'b0; ext_type_i = '0;
    @(negedge clk);
    tick(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 valid", irq_valid_o, 0);
    chk("R1 vector", irq_vector_o, 0);
    chk("R1 pin_out", pin_out_o, 0);
    chk("R1 pin_oe", pin_oe_o, 0);

    // R2 / R5: every level pattern, winner is the lowest set line
    for (int p = 1; p < 16; p++) begin
      req_pin_i = 4'(p);
      tick(2);
      chk("R2 not early", irq_valid_o, 0);
      tick(1);
      chk("R2 valid", irq_valid_o, 1);
      chk("R5 vector", irq_vector_o, 12 + lowest(p));
      req_pin_i = '0;
      tick(3);
      ack();
      chk("R6 drop", irq_valid_o, 0);
      tick(3);
      chk("R6 idle", irq_valid_o, 0);
    end

    // R4: mask sweep with all lines held
    for (int m = 0; m < 16; m++) begin
      mask_i = 4'(m);
      req_pin_i = 4'hF;
      tick(3);
      chk("R4 valid", irq_valid_o, (m != 15) ? 1 : 0);
      if (m != 15) chk("R4 vector", irq_vector_o, 12 + lowest(~m & 15));
      req_pin_i = '0;
      tick(3);
      if (irq_valid_o) ack();
      tick(3);
    end
    mask_i = '0;

    // R3 / R11: edge mode on line 2
    edge_mode_i = 4'b0100;
    tick(1);
    req_pin_i = 4'b0100;
    tick(2);
    req_pin_i = '0;
    tick(1);
    chk("R3 edge not early", irq_valid_o, 0);
    tick(1);
    chk("R3 edge valid", irq_valid_o, 1);
    chk("R3 edge vector", irq_vector_o, 14);
    ack();
    tick(4);
    chk("R11 no repeat", irq_valid_o, 0);

    // R4: edge recorded while masked
    mask_i = 4'b0100;
    req_pin_i = 4'b0100;
    tick(2);
    req_pin_i = '0;
    tick(4);
    chk("R4 masked edge", irq_valid_o, 0);
    mask_i = '0;
    tick(1);
    chk("R4 unmask valid", irq_valid_o, 1);
    chk("R4 unmask vector", irq_vector_o, 14);
    ack();
    tick(2);

    // R3: level pulse while masked leaves nothing
    edge_mode_i = '0;
    mask_i = 4'b0100;
    req_pin_i = 4'b0100;
    tick(2);
    req_pin_i = '0;
    tick(4);
    mask_i = '0;
    tick(1);
    chk("R3 level gone", irq_valid_o, 0);

    // R6: presented vector held against a higher request
    req_pin_i = 4'b1000;
    tick(3);
    chk("R6 first", irq_vector_o, 15);
    req_pin_i = 4'b1001;
    tick(4);
    chk("R6 held", irq_vector_o, 15);
    req_pin_i = 4'b0001;
    tick(3);
    ack();
    chk("R6 gap", irq_valid_o, 0);
    tick(1);
    chk("R6 next valid", irq_valid_o, 1);
    chk("R6 next vector", irq_vector_o, 12);
    req_pin_i = '0;
    tick(3);
    ack();
    tick(2);

    // R7: cascade on line 0
    casc_en_i = 2'b01;
    tick(1);
    chk("R7 oe", pin_oe_o, 4);
    ext_type_i = 8'h11;
    req_pin_i = 4'b0001;
    tick(3);
    chk("R7 ack high", pin_out_o, 4);
    chk("R7 no valid", irq_valid_o, 0);
    tick(1);
    chk("R7 ack low", pin_out_o, 0);
    ext_type_i = 8'hC3;
    tick(1);
    chk("R7 valid", irq_valid_o, 1);
    chk("R7 type", irq_vector_o, 8'hC3);
    ext_type_i = 8'h55;
    tick(1);
    chk("R7 type held", irq_vector_o, 8'hC3);
    req_pin_i = '0;
    tick(3);
    ack();
    tick(2);
    req_pin_i = 4'b0100;
    tick(5);
    chk("R7 pin2 not request", irq_valid_o, 0);
    chk("R7 pin2 quiet", pin_out_o, 0);
    req_pin_i = '0;
    tick(3);

    // R8: cascade on line 1
    casc_en_i = 2'b10;
    tick(1);
    chk("R8 oe", pin_oe_o, 8);
    ext_type_i = 8'h22;
    req_pin_i = 4'b0010;
    tick(3);
    chk("R8 ack high", pin_out_o, 8);
    tick(1);
    chk("R8 ack low", pin_out_o, 0);
    ext_type_i = 8'h6B;
    tick(1);
    chk("R8 valid", irq_valid_o, 1);
    chk("R8 type", irq_vector_o, 8'h6B);
    req_pin_i = '0;
    tick(3);
    ack();
    tick(2);

    // R9: slave mode select capture
    casc_en_i = '0;
    slave_en_i = 1'b1;
    tick(1);
    chk("R10 oe", pin_oe_o, 8);
    ext_type_i = 8'h77;
    req_pin_i = 4'b0010;
    tick(4);
    chk("R9 select alone", irq_valid_o, 0);
    req_pin_i = '0;
    tick(3);
    req_pin_i = 4'b0001;
    tick(3);
    chk("R9 line0 alone", irq_valid_o, 0);
    ext_type_i = 8'h9E;
    req_pin_i = 4'b0011;
    tick(2);
    chk("R9 not early", irq_valid_o, 0);
    tick(1);
    chk("R9 valid", irq_valid_o, 1);
    chk("R9 type", irq_vector_o, 8'h9E);
    req_pin_i = '0;
    tick(3);
    ack();
    chk("R9 ack", irq_valid_o, 0);
    tick(2);

    // R10: line 2 forwarded on pin 3
    req_pin_i = 4'b0100;
    tick(3);
    chk("R10 req out", pin_out_o, 8);
    chk("R10 not to cpu", irq_valid_o, 0);
    mask_i = 4'b0100;
    tick(1);
    chk("R10 masked", pin_out_o, 0);
    req_pin_i = '0;
    mask_i = '0;
    tick(3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule